// File: doc/BRIEF.md
# Two-Stage Card Serial Clock Generator

This block derives the serial clock for a memory-card bus from a fast functional clock. The division has two stages. A prescaler divides by an even value, and a rate counter then divides that result by (rate + 1). Both values sit in a 16-bit timing word. The divide field is in bits 15:8 and the rate field is in bits 7:0. The output frequency is therefore the functional clock divided by divide × (rate + 1), with a 50% duty cycle.

Next to the clock itself, the block produces two one-cycle strobes in the functional clock domain. One marks each rising edge and one marks each falling edge. The command and data shift logic uses these strobes instead of the divided clock. The clock only runs when something needs it. It runs during a transfer, whenever continuous clocking is enabled, and for an eight-cycle tail after a command. At all other times it is parked low. New timing values are taken up only at a rising boundary of the serial clock, so no phase is ever shortened.

Top module: `serclk_gen`

## Requirements
- R1: After reset the timing word reads 16'h0200 (divide 2, rate 0), the serial clock is low and both edge strobes are low.
- R2: A write captures the rate as given. The divide value is stored with bit 8 of the word forced to 0, and a stored value of 0 becomes 2. The word reads back the new value from the cycle after the write.
- R3: While running, each high phase and each low phase lasts (divide/2) × (rate + 1) functional cycles. The full period is divide × (rate + 1) cycles.
- R4: The rise strobe is high for exactly the first cycle the serial clock is high. The fall strobe is high for exactly the first cycle it is low. The two strobes are never high together, and the clock never changes without one of them.
- R5: With no transfer, no continuous clocking and no pending tail, the clock stays low and produces no edges. If the request drops during a high phase, that phase still runs its full length before the clock parks low.
- R6: When a request arrives at the stopped generator, the first rising edge comes exactly one half-period after the first cycle in which the request is sampled. No phase is shorter than that.
- R7: Continuous clocking alone keeps the clock running without a transfer request.
- R8: A tail request produces exactly eight rising edges and then parks the clock low, provided nothing else requests the clock.
- R9: Timing written while the clock runs does not change the phase in progress or the low phase that follows it. It takes effect from the next rising edge onward.
- R10: The largest setting, divide 254 with rate 255, gives a half period of 32512 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the timing word |
| cfg_divide | input | 8 | Prescaler value to write (even, 2 to 254) |
| cfg_rate | input | 8 | Rate value to write (0 to 255) |
| xfer_active | input | 1 | A command or data transfer needs the clock |
| cont_clk_en | input | 1 | Keep the clock running between transfers |
| tail_req | input | 1 | Pulse: append eight clocks after a command |
| sclk | output | 1 | Divided serial clock |
| rise_en | output | 1 | One-cycle strobe on each rising edge |
| fall_en | output | 1 | One-cycle strobe on each falling edge |
| timing_q | output | 16 | Stored timing word: divide in 15:8, rate in 7:0 |

## Verification
Some properties are checked by assertions on every cycle. These are the shape of the edge strobes and their exclusivity, the rule that the clock never toggles without a strobe, the rule that no rising edge occurs without a prior run request, and the capture and even-forcing of the timing word.

Other properties can only be shown by the bench scenarios. These are the exact phase lengths for several divide and rate pairs, including the extreme setting. They also include the latency of the first edge after a start, the full-length final high phase when a request drops, the count of tail edges, and the deferral of a mid-run timing change to the next rising edge.

// File: rtl/serclk_pkg.sv
// Shared field width and timing word layout for the serial clock generator.
package serclk_pkg;
    localparam int FIELD_W = 8;

    typedef struct packed {
        logic [FIELD_W-1:0] divide;   // upper byte: even prescaler
        logic [FIELD_W-1:0] rate;     // lower byte: rate counter limit
    } timing_t;
endpackage

// File: rtl/serclk_cfg.sv
// Timing word register. Forces the divide value even and at least 2.
// Assumes writes are single-cycle strobes in the functional clock domain.
module serclk_cfg
    import serclk_pkg::*;
#(
    parameter int RESET_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [FIELD_W-1:0] divide_in,
    input  logic [FIELD_W-1:0] rate_in,
    output timing_t            cfg
);
    logic [FIELD_W-1:0] div_legal;

    // Legalise the divide value: clear bit 0, replace zero by two.
    always_comb begin
        div_legal = {divide_in[FIELD_W-1:1], 1'b0};
        if (div_legal == '0) div_legal = FIELD_W'(2);
    end

    // Hold the programmed timing word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.divide <= FIELD_W'(RESET_DIV);
            cfg.rate   <= '0;
        end else if (wr) begin
            cfg.divide <= div_legal;
            cfg.rate   <= rate_in;
        end
    end
endmodule

// File: rtl/serclk_stage.sv
// One divider stage: counts steps from 0 to 'last' and flags the wrap.
// Assumes 'last' is held stable while the stage is counting.
module serclk_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic         wrap
);
    logic [W-1:0] cnt;

    assign wrap = step && !clr && (cnt == last);

    // Advance the count, restarting after the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (wrap)      cnt <= '0;
        else if (step)      cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/serclk_tail.sv
// Counts the extra rising edges appended after a command.
// Assumes 'rise' is high for one cycle per rising serial edge.
module serclk_tail #(
    parameter int TAIL_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic rise,
    output logic busy
);
    localparam int TW = $clog2(TAIL_CYCLES + 1);
    logic [TW-1:0] left;

    assign busy = (left != '0);

    // Load the tail length, then decrement on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)              left <= '0;
        else if (load)           left <= TW'(TAIL_CYCLES);
        else if (rise && busy)   left <= left - TW'(1);
    end
endmodule

// File: rtl/serclk_gen.sv
// Two-stage serial clock generator: prescaler by divide/2, then rate+1,
// toggling the output each time both stages wrap. Gated low when idle.
// Assumes all inputs are synchronous to clk.
module serclk_gen
    import serclk_pkg::*;
#(
    parameter int TAIL_CYCLES = 8,
    parameter int RESET_DIV   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [FIELD_W-1:0]   cfg_divide,
    input  logic [FIELD_W-1:0]   cfg_rate,
    input  logic                 xfer_active,
    input  logic                 cont_clk_en,
    input  logic                 tail_req,
    output logic                 sclk,
    output logic                 rise_en,
    output logic                 fall_en,
    output logic [2*FIELD_W-1:0] timing_q
);
    localparam int HALF_W = FIELD_W - 1;

    timing_t           cfg_q;
    timing_t           act_q;
    logic              sclk_q, rise_q, fall_q;
    logic              run_req, active, tail_busy;
    logic              pre_wrap, rate_wrap, rise_evt;
    logic [HALF_W-1:0] half_last;

    serclk_cfg #(.RESET_DIV(RESET_DIV)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
        .divide_in(cfg_divide), .rate_in(cfg_rate), .cfg(cfg_q)
    );

    assign run_req   = xfer_active || cont_clk_en || tail_busy;
    assign active    = run_req || sclk_q;
    assign half_last = act_q.divide[FIELD_W-1:1] - HALF_W'(1);

    serclk_stage #(.W(HALF_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(!active), .step(active),
        .last(half_last), .wrap(pre_wrap)
    );

    serclk_stage #(.W(FIELD_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .clr(!active), .step(pre_wrap),
        .last(act_q.rate), .wrap(rate_wrap)
    );

    assign rise_evt = rate_wrap && !sclk_q;

    serclk_tail #(.TAIL_CYCLES(TAIL_CYCLES)) u_tail (
        .clk(clk), .rst_n(rst_n), .load(tail_req), .rise(rise_evt),
        .busy(tail_busy)
    );

    // Take up new timing only while stopped or at a rising boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q.divide <= FIELD_W'(RESET_DIV);
            act_q.rate   <= '0;
        end else if (!active || rise_evt) begin
            act_q <= cfg_q;
        end
    end

    // Toggle the serial clock and register the matching edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            if (rate_wrap) sclk_q <= !sclk_q;
            rise_q <= rate_wrap && !sclk_q;
            fall_q <= rate_wrap && sclk_q;
        end
    end

    assign sclk     = sclk_q;
    assign rise_en  = rise_q;
    assign fall_en  = fall_q;
    assign timing_q = cfg_q;
endmodule

// File: rtl/serclk_gen_chk.sv
// Property checker for serclk_gen, attached by bind.
module serclk_gen_chk
    import serclk_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sclk,
    input logic                 rise_en,
    input logic                 fall_en,
    input logic                 cfg_wr,
    input logic [FIELD_W-1:0]   cfg_rate,
    input logic [2*FIELD_W-1:0] timing_q,
    input logic                 run_req
);
    // R4
    rise_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_en |-> (sclk && !$past(sclk)));

    // R4
    fall_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_en |-> (!sclk && $past(sclk)));

    // R4
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_en, fall_en}));

    // R4
    sclk_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != $past(sclk)) |-> (rise_en || fall_en));

    // R5
    rise_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_en |-> $past(run_req));

    // R2
    rate_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (timing_q[FIELD_W-1:0] == $past(cfg_rate)));

    // R2
    div_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!timing_q[FIELD_W] && (timing_q[2*FIELD_W-1:FIELD_W] != '0)));
endmodule

bind serclk_gen serclk_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .rise_en(rise_en),
    .fall_en(fall_en), .cfg_wr(cfg_wr), .cfg_rate(cfg_rate),
    .timing_q(timing_q), .run_req(run_req)
);

// File: tb/serclk_gen_bench.sv
// Scoreboard bench: driver tasks queue expected edge spacings, the monitor
// pops one per observed edge and compares it with the measured spacing.
module serclk_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_divide = 8'd0;
    logic [7:0]  cfg_rate = 8'd0;
    logic        xfer_active = 1'b0;
    logic        cont_clk_en = 1'b0;
    logic        tail_req = 1'b0;
    logic        sclk, rise_en, fall_en;
    logic [15:0] timing_q;

    int total = 0;
    int bad = 0;
    int exp_q[$];
    int gap = 0;
    int rise_total = 0;
    int pulse_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serclk_gen u_serclk_gen (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_divide(cfg_divide),
        .cfg_rate(cfg_rate), .xfer_active(xfer_active),
        .cont_clk_en(cont_clk_en), .tail_req(tail_req), .sclk(sclk),
        .rise_en(rise_en), .fall_en(fall_en), .timing_q(timing_q)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: measure edge spacing and compare with queued expectations.
    always @(negedge clk) begin
        if (rst_n) begin
            gap++;
            if (rise_en && (fall_en || !sclk)) pulse_err++;
            if (fall_en && sclk) pulse_err++;
            if (rise_en) rise_total++;
            if (rise_en || fall_en) begin
                if (exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    if (e != 0) chk(gap == e, "R3 R7 R9 R10 edge spacing", gap, e);
                end
                gap = 0;
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(input int d, input int r);
        cfg_divide = 8'(d);
        cfg_rate   = 8'(r);
        cfg_wr     = 1'b1;
        tick();
        cfg_wr     = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 70000 && sclk; i++) tick();
        repeat (4) tick();
    endtask

    // Driver: run continuous clocking and queue n expected half periods.
    task automatic run_cont(input int d, input int r, input int n);
        int h;
        h = (d / 2) * (r + 1);
        write_cfg(d, r);
        tick();
        @(negedge clk);
        #1;
        exp_q.push_back(0);
        for (int i = 0; i < n; i++) exp_q.push_back(h);
        tick();
        cont_clk_en = 1'b1;
        for (int i = 0; i < 150000 && exp_q.size() > 0; i++) tick();
        cont_clk_en = 1'b0;
        wait_idle();
    endtask

    initial begin
        int k;
        int r0;
        repeat (3) tick();
        // R1 reset state
        chk(timing_q == 16'h0200, "R1 timing word", timing_q, 16'h0200);
        chk(sclk == 1'b0 && !rise_en && !fall_en, "R1 outputs low", sclk, 0);
        rst_n = 1'b1;
        tick();

        // R2 field capture and divide legalisation
        write_cfg(5, 3);
        chk(timing_q == 16'h0403, "R2 odd divide", timing_q, 16'h0403);
        write_cfg(0, 255);
        chk(timing_q == 16'h02FF, "R2 zero divide", timing_q, 16'h02FF);
        write_cfg(1, 7);
        chk(timing_q == 16'h0207, "R2 divide one", timing_q, 16'h0207);
        write_cfg(254, 0);
        chk(timing_q == 16'hFE00, "R2 max divide", timing_q, 16'hFE00);

        // R3 R7 spacing under continuous clocking
        run_cont(2, 0, 6);
        run_cont(4, 2, 6);
        run_cont(5, 1, 4);
        run_cont(10, 3, 4);

        // R6 first edge latency from stopped
        write_cfg(4, 2);
        repeat (2) tick();
        xfer_active = 1'b1;
        k = 0;
        for (int i = 0; i < 100 && !sclk; i++) begin tick(); k++; end
        chk(k == 6, "R6 first rise latency", k, 6);

        // R5 request drop during high phase: full phase, then parked
        xfer_active = 1'b0;
        k = 0;
        for (int i = 0; i < 100 && sclk; i++) begin tick(); k++; end
        chk(k == 6, "R5 final high phase", k, 6);
        r0 = rise_total;
        repeat (60) tick();
        chk(rise_total == r0 && !sclk, "R5 parked low", rise_total - r0, 0);

        // R8 eight-edge tail at two settings
        write_cfg(2, 0);
        repeat (2) tick();
        r0 = rise_total;
        tail_req = 1'b1; tick(); tail_req = 1'b0;
        repeat (60) tick();
        chk(rise_total - r0 == 8, "R8 tail edges fast", rise_total - r0, 8);
        chk(!sclk, "R8 parked after tail", sclk, 0);
        write_cfg(4, 2);
        repeat (2) tick();
        r0 = rise_total;
        tail_req = 1'b1; tick(); tail_req = 1'b0;
        repeat (200) tick();
        chk(rise_total - r0 == 8, "R8 tail edges slow", rise_total - r0, 8);

        // R9 mid-run change deferred to the next rising edge
        write_cfg(2, 2);
        repeat (2) tick();
        cont_clk_en = 1'b1;
        for (int i = 0; i < 100 && !rise_en; i++) tick();
        cfg_divide = 8'd8; cfg_rate = 8'd1; cfg_wr = 1'b1;
        tick();
        cfg_wr = 1'b0;
        @(negedge clk);
        #1;
        exp_q.push_back(3); exp_q.push_back(3);
        exp_q.push_back(8); exp_q.push_back(8);
        for (int i = 0; i < 200 && exp_q.size() > 0; i++) tick();
        chk(exp_q.size() == 0, "R9 edges seen", exp_q.size(), 0);
        cont_clk_en = 1'b0;
        wait_idle();

        // R10 extreme setting
        run_cont(254, 255, 1);

        // R4 strobe shape over the whole run
        chk(pulse_err == 0, "R4 strobe shape", pulse_err, 0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule